// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. A one-cycle start request makes it clear the external integrator for a short fixed interval. It then steers the integrator input to the unknown signal for an exact run-up time of 2^N clocks. After that it steers the integrator to the negative reference and counts clocks until the comparator reports that the integrator has returned through zero. The count is proportional to the input over the reference, scaled by the fixed run-up time. It is latched as the result and announced with a single-cycle completion pulse.

The comparator is brought in through a short synchronizer. The run-down counter is one bit wider than the run-up count, so an input above full scale is detected. If the comparator never trips, the block stops at the counter's ceiling and marks the result as overrange. Start requests that arrive during a conversion are dropped. The result and the overrange flag stay unchanged between completions.

Top module: `dslope_seq`

## Requirements
- R1: While reset is held and after it is released, the outputs are: switch select 2'b00, integrator clear 0, busy 0, done 0, result 0, overrange 0.
- R2: A start sampled high while idle raises busy from the next cycle. The integrator clear output is then high for exactly RST_CYCLES consecutive clocks, with switch select 2'b00 during that time.
- R3: The clear interval is followed by exactly 2^N consecutive clocks with switch select 2'b01 (input). This count is the same in every conversion.
- R4: After run-up, switch select is 2'b10 (reference) until the conversion ends. Switch select never takes the value 2'b11.
- R5: The comparator input is 1 while the integrator is above zero. If it stays 1 for K rising edges of run-down and then reads 0, the result is K + SYNC_STAGES, provided that sum does not exceed 2^(N+1)-1.
- R6: If the count reaches 2^(N+1)-1 while the synchronized comparator still reads 1, the conversion ends with result 2^(N+1)-1 and overrange 1. A conversion that ends normally clears overrange.
- R7: A start request during a conversion has no effect: the phase lengths are unchanged and only one completion occurs.
- R8: Done is high for one cycle, in the cycle where busy has fallen. Result and overrange change only on a completion and hold their values in between.
- R9: Busy stays high without a break from the cycle after start through the last run-down clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_i | input | 1 | Comparator, 1 = integrator above zero |
| sel_o | output | 2 | Integrator source: 00 hold, 01 input, 10 reference |
| int_clr_o | output | 1 | Integrator clear |
| result_o | output | N+1 | Run-down count of the last conversion |
| ovr_o | output | 1 | Last conversion hit the count ceiling |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench drives runs with an immediate trip, mid-scale counts, and a count that lands exactly on the ceiling. It also drives runs one clock past the ceiling and far beyond it. An off-by-one in the terminal compare would either flag the exact-ceiling case as overrange or miss overrange on the next one. A synchronizer latency left out of the count would shift every result. The bench counts clear and run-up clocks in every conversion and fires extra start requests during run-up. A design that restarted, or that stretched the run-up, would show a changed run-up length or a second completion. A conversion that ends normally after an overrange one must drop the overrange flag, or the stale flag is reported.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CLR   = 2'd1,
        ST_RUNUP = 2'd2,
        ST_RDOWN = 2'd3
    } dsq_state_e;

    localparam logic [1:0] SEL_HOLD  = 2'b00;
    localparam logic [1:0] SEL_INPUT = 2'b01;
    localparam logic [1:0] SEL_REF   = 2'b10;
endpackage

// File: rtl/dsq_sync.sv
module dsq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    output logic y_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign y_o = a_i;
        end else begin : g_chain
            logic [STAGES-1:0] sh_d, sh_q;
            always_comb begin
                sh_d = {sh_q[STAGES-1:0], a_i} >> 0;
                if (STAGES > 1) sh_d = {sh_q, a_i} >> 0;
            end
            always_ff @(posedge clk) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end
            assign y_o = sh_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dsq_counter.sv
module dsq_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)      cnt_d = '0;
        else if (inc_i) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dsq_pkg::*;
#(
    parameter int N           = 6,
    parameter int RST_CYCLES  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         cmp_i,
    output logic [1:0]   sel_o,
    output logic         int_clr_o,
    output logic [N:0]   result_o,
    output logic         ovr_o,
    output logic         busy_o,
    output logic         done_o
);
    localparam int          CW        = N + 1;
    localparam logic [CW-1:0] RUNUP_LAST = CW'((1 << N) - 1);
    localparam logic [CW-1:0] CLR_LAST   = CW'(RST_CYCLES - 1);
    localparam logic [CW-1:0] CEIL       = '1;

    typedef struct packed {
        dsq_state_e    st;
        logic          done;
        logic          ovr;
        logic [CW-1:0] res;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    logic          cmp_s;

    dsq_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .a_i   (cmp_i),
        .y_o   (cmp_s)
    );

    dsq_counter #(.W(CW)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .inc_i (cnt_inc),
        .cnt_o (cnt)
    );

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_CLR;
                    cnt_clr = 1'b1;
                end
            end
            ST_CLR: begin
                if (cnt == CLR_LAST) begin
                    r_d.st  = ST_RUNUP;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_RUNUP: begin
                if (cnt == RUNUP_LAST) begin
                    r_d.st  = ST_RDOWN;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            ST_RDOWN: begin
                if (!cmp_s) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = cnt;
                    r_d.ovr  = 1'b0;
                end else if (cnt == CEIL) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = cnt;
                    r_d.ovr  = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, done: 1'b0, ovr: 1'b0, res: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        unique case (r_q.st)
            ST_RUNUP: sel_o = SEL_INPUT;
            ST_RDOWN: sel_o = SEL_REF;
            default:  sel_o = SEL_HOLD;
        endcase
    end

    assign int_clr_o = (r_q.st == ST_CLR);
    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = r_q.done;
    assign result_o  = r_q.res;
    assign ovr_o     = r_q.ovr;
endmodule

// File: rtl/dsq_checker.sv
module dsq_checker #(
    parameter int N = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [1:0] sel_o,
    input logic       int_clr_o,
    input logic [N:0] result_o,
    input logic       ovr_o,
    input logic       busy_o,
    input logic       done_o
);
    p_idle_sel_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (sel_o == 2'b00 && !int_clr_o));

    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    p_clr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_clr_o |-> (sel_o == 2'b00 && busy_o));

    p_sel_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    p_ceiling_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ovr_o) |-> (&result_o));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(sel_o) == 2'b10));
endmodule

bind dslope_seq dsq_checker #(.N(N)) i_dsq_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .sel_o     (sel_o),
    .int_clr_o (int_clr_o),
    .result_o  (result_o),
    .ovr_o     (ovr_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/test_dslope_seq.sv
module test_dslope_seq;
    localparam int N    = 4;
    localparam int RSTC = 3;
    localparam int SYNC = 2;
    localparam int T1   = 1 << N;
    localparam int CEIL = (1 << (N + 1)) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         cmp_i = 1'b1;
    logic [1:0]   sel_o;
    logic         int_clr_o;
    logic [N:0]   result_o;
    logic         ovr_o;
    logic         busy_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;
    logic [N+1:0] expq[$];

    always #2.5 clk = ~clk;

    dslope_seq #(.N(N), .RST_CYCLES(RSTC), .SYNC_STAGES(SYNC)) i_dslope_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
        .sel_o(sel_o), .int_clr_o(int_clr_o), .result_o(result_o),
        .ovr_o(ovr_o), .busy_o(busy_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Monitor: pops expected {ovr, result} on every completion.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7 unexpected completion", 1, 0);
            end else begin
                logic [N+1:0] e;
                e = expq.pop_front();
                check(result_o == e[N:0], "R5/R6 result", int'(result_o), int'(e[N:0]));
                check(ovr_o == e[N+1], "R6 overrange flag", int'(ovr_o), int'(e[N+1]));
                check(!busy_o, "R8 busy low at done", int'(busy_o), 0);
            end
        end
    end

    // Driver: one conversion with K high run-down edges.
    task automatic convert(input int k, input bit extra_start);
        int clr_n = 0;
        int run_n = 0;
        int r = k + SYNC;
        logic [N+1:0] e;
        e = (r > CEIL) ? {1'b1, (N+1)'(CEIL)} : {1'b0, (N+1)'(r)};
        expq.push_back(e);
        @(negedge clk);
        cmp_i   = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o, "R9 busy after start", int'(busy_o), 1);
        while (sel_o != 2'b10) begin
            if (int_clr_o) clr_n++;
            if (sel_o == 2'b01) begin
                run_n++;
                start_i = extra_start && (run_n == 3);
            end else begin
                start_i = 1'b0;
            end
            check(busy_o, "R9 busy during phases", int'(busy_o), 1);
            @(negedge clk);
        end
        start_i = 1'b0;
        check(clr_n == RSTC, "R2 clear length", clr_n, RSTC);
        check(run_n == T1, "R3 run-up length", run_n, T1);
        for (int i = 0; i < k && busy_o; i++) begin
            check(sel_o == 2'b10, "R4 reference select", int'(sel_o), 2);
            @(negedge clk);
        end
        cmp_i = 1'b0;
        while (busy_o) @(negedge clk);
        repeat (6) @(negedge clk);
        check(result_o == e[N:0], "R8 result held", int'(result_o), int'(e[N:0]));
        check(done_o == 1'b0, "R8 done single pulse", int'(done_o), 0);
        check(expq.size() == 0, "R7 single completion", expq.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(sel_o == 2'b00 && !int_clr_o && !busy_o && !done_o &&
              result_o == '0 && !ovr_o, "R1 reset state", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && sel_o == 2'b00, "R1 idle after reset", int'(busy_o), 0);
        convert(0, 1'b0);                 // immediate trip
        convert(5, 1'b0);                 // mid-scale
        convert(13, 1'b1);                // start during run-up ignored (R7)
        convert(CEIL - SYNC, 1'b0);       // lands exactly on ceiling, no overrange
        convert(CEIL - SYNC + 1, 1'b0);   // one past ceiling: overrange (R6)
        convert(200, 1'b0);               // far beyond ceiling
        convert(3, 1'b0);                 // normal result clears overrange (R6)
        check(ovr_o == 1'b0, "R6 overrange cleared", int'(ovr_o), 0);
        finish_run();
    end
endmodule